// File: doc/BRIEF.md
# Watchdog Timer and Reset Controller

This peripheral watches for stalled software and manages chip-level reset requests. An 8-bit binary counter advances once per prescaler period. The period is chosen from five oscillator divisors. If software does not restart the counter before it wraps, the block raises a watchdog event. When reset-on-overflow is enabled, that event is a timed chip reset pulse plus a sticky cause flag. Otherwise it is a single-cycle non-maskable alert intended for the CPU.

Software reaches three byte-wide registers through a simple write strobe and a combinational read port. The registers are the counter (read-only), the watchdog control and the reset control. Software can also force a chip reset by clearing and then setting a request bit. An external double-fault input also produces a chip reset and leaves its own sticky cause flag. The cause flags survive the reset pulse that the block itself drives, so boot code can read why the chip restarted. Only a power-on reset or an explicit software write of 0 clears them.

Top module: `wdt_rstctl`

## Requirements
- R1: Reads at address 0 return the counter, at address 2 return {enable bit 7, 0 at bit 6, zeros at bits 5:3, divisor select at bits 2:0}, and at address 4 return {zeros at bits 7:4, reset enable bit 3, watchdog flag bit 2, double-fault flag bit 1, software request bit 0}. Every other address reads 0, and writes to address 0 leave the counter unchanged.
- R2: Divisor select codes 0..4 give prescaler periods of 2^EXP0..2^EXP4 clocks (defaults 256, 1024, 2048, 16384, 65536). Suppose a control write with enable and clear set lands on clock edge k. After edge k+j the counter then reads floor(j/period), modulo 256.
- R3: Divisor select codes 5, 6 and 7 behave exactly like code 4.
- R4: Writing control bit 6 as 1 clears the counter and the prescaler at that write's edge. The bit is not stored and reads back as 0.
- R5: While the enable bit (control bit 7) is 0, the counter holds its value.
- R6: When the counter wraps from 255 to 0 with reset enable set, chipRst goes high after the wrapping edge and stays high for PULSE_LEN (default 16) cycles. The watchdog flag is set at the same time.
- R7: When the counter wraps with reset enable clear, wdtIrq is high for exactly one cycle after the wrapping edge. chipRst stays low and the watchdog flag is unchanged.
- R8: A reset-control write with bit 0 = 1 while the stored request bit is 0 starts a PULSE_LEN-cycle chipRst pulse. Writing bit 0 = 1 while it is already 1 starts no pulse.
- R9: A cycle with dblFault high sets the double-fault flag and starts a PULSE_LEN-cycle chipRst pulse from the next edge.
- R10: Writing 0 to a cause flag clears it and writing 1 leaves it unchanged. A flag set in the same cycle as a clearing write stays set. The flags are unaffected by the block's own chipRst.
- R11: A power-on reset (rstPorN low) clears every register. chipRst and wdtIrq are then low and all three addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; also the prescaler source |
| rstPorN | input | 1 | Asynchronous power-on reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for addr |
| dblFault | input | 1 | Double-fault reset request, one cycle per event |
| chipRst | output | 1 | Chip reset request pulse |
| wdtIrq | output | 1 | One-cycle watchdog alert when reset is disabled |

## Verification
The bound checker checks these properties on every cycle:
- the alert never lasts more than one cycle;
- a reset pulse never ends before its full length;
- a double fault is always followed by a reset pulse;
- the counter never moves while counting is disabled and no clear is written.

Other behaviour is visible only through the bench's scenarios:
- the exact wrap cycle for each divisor code, including the codes that alias to the slowest divisor;
- which event (alert or pulse) an overflow produces;
- the clear-then-set arming of the software request;
- the sticky flag semantics across clearing writes and power-on reset.

The bench runs these scenarios with small divisor exponents so that a full counter wrap fits in a short run.

// File: rtl/wdt_rstctl_pkg.sv
package wdt_rstctl_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int NUM_DIV = 5;

  localparam logic [ADDR_W-1:0] OFS_CNT = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CTL = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_RST = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic       cntEn;
    logic       cntClr;
    logic [2:0] divSel;
  } dpStrb_t;
endpackage

// File: rtl/wdt_rstctl_dp.sv
module wdt_rstctl_dp
  import wdt_rstctl_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int EXP0  = 8,
  parameter int EXP1  = 10,
  parameter int EXP2  = 11,
  parameter int EXP3  = 14,
  parameter int EXP4  = 16
) (
  input  logic             clk,
  input  logic             rstPorN,
  input  dpStrb_t          strb,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovfPulse
);
  localparam int EXPS [NUM_DIV] = '{EXP0, EXP1, EXP2, EXP3, EXP4};
  localparam int M01   = (EXP0 > EXP1) ? EXP0 : EXP1;
  localparam int M23   = (EXP2 > EXP3) ? EXP2 : EXP3;
  localparam int M03   = (M01 > M23) ? M01 : M23;
  localparam int M04   = (M03 > EXP4) ? M03 : EXP4;
  localparam int PRE_W = (M04 > 0) ? M04 : 1;

  logic [PRE_W-1:0] maskTab [NUM_DIV];
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] selMask;
  logic [2:0]       selIdx;
  logic             tick;

  for (genvar g = 0; g < NUM_DIV; g++) begin : gMask
    localparam int E = EXPS[g];
    assign maskTab[g] = PRE_W'((64'(1) << E) - 64'(1));
  end

  // codes above the last divisor alias to the slowest one
  assign selIdx  = (strb.divSel > 3'(NUM_DIV - 1)) ? 3'(NUM_DIV - 1) : strb.divSel;
  assign selMask = maskTab[selIdx];
  assign tick    = strb.cntEn && ((preCnt & selMask) == selMask);
  assign ovfPulse = tick && (cntVal == '1);

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      preCnt <= '0;
      cntVal <= '0;
    end else if (strb.cntClr) begin
      preCnt <= '0;
      cntVal <= '0;
    end else if (strb.cntEn) begin
      preCnt <= preCnt + 1'b1;
      if (tick) cntVal <= cntVal + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_rstctl_ctrl.sv
module wdt_rstctl_ctrl
  import wdt_rstctl_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dblFault,
  input  logic              ovfPulse,
  input  logic [CNT_W-1:0]  cntVal,
  output dpStrb_t           strb,
  output logic [DATA_W-1:0] rdData,
  output logic              chipRst,
  output logic              wdtIrq
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic          enReg, rstEnReg, wdFlag, dfFlag, swReq, irqReg;
  logic [2:0]    selReg;
  logic [PW-1:0] pulseCnt;
  logic          ctlWr, rstWr, swTrig, wdTrig, fire;

  assign ctlWr  = wrEn && (addr == OFS_CTL);
  assign rstWr  = wrEn && (addr == OFS_RST);
  assign swTrig = rstWr && wrData[0] && !swReq;
  assign wdTrig = ovfPulse && rstEnReg;
  assign fire   = swTrig || wdTrig || dblFault;

  assign strb.cntEn  = enReg;
  assign strb.cntClr = ctlWr && wrData[6];
  assign strb.divSel = selReg;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      enReg    <= 1'b0;
      selReg   <= '0;
      rstEnReg <= 1'b0;
      swReq    <= 1'b0;
      wdFlag   <= 1'b0;
      dfFlag   <= 1'b0;
      pulseCnt <= '0;
      irqReg   <= 1'b0;
    end else begin
      if (ctlWr) begin
        enReg  <= wrData[7];
        selReg <= wrData[2:0];
      end
      if (rstWr) begin
        rstEnReg <= wrData[3];
        swReq    <= wrData[0];
      end
      // set beats a clearing write in the same cycle
      wdFlag <= wdTrig   || (wdFlag && (!rstWr || wrData[2]));
      dfFlag <= dblFault || (dfFlag && (!rstWr || wrData[1]));
      if (fire)                pulseCnt <= PW'(PULSE_LEN);
      else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
      irqReg <= ovfPulse && !rstEnReg;
    end
  end

  assign chipRst = (pulseCnt != '0);
  assign wdtIrq  = irqReg;

  always_comb begin
    rdData = '0;
    case (addr)
      OFS_CNT: rdData[CNT_W-1:0] = cntVal;
      OFS_CTL: rdData = {enReg, 4'b0000, selReg};
      OFS_RST: rdData = {4'b0000, rstEnReg, wdFlag, dfFlag, swReq};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/wdt_rstctl.sv
module wdt_rstctl
  import wdt_rstctl_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 16,
  parameter int EXP0      = 8,
  parameter int EXP1      = 10,
  parameter int EXP2      = 11,
  parameter int EXP3      = 14,
  parameter int EXP4      = 16
) (
  input  logic       clk,
  input  logic       rstPorN,
  input  logic       wrEn,
  input  logic [2:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       dblFault,
  output logic       chipRst,
  output logic       wdtIrq
);
  dpStrb_t          strb;
  logic [CNT_W-1:0] cntVal;
  logic             ovfPulse;

  wdt_rstctl_ctrl #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) ctrl_i (
    .clk(clk), .rstPorN(rstPorN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .dblFault(dblFault), .ovfPulse(ovfPulse), .cntVal(cntVal), .strb(strb),
    .rdData(rdData), .chipRst(chipRst), .wdtIrq(wdtIrq)
  );

  wdt_rstctl_dp #(
    .CNT_W(CNT_W), .EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3), .EXP4(EXP4)
  ) dp_i (
    .clk(clk), .rstPorN(rstPorN), .strb(strb), .cntVal(cntVal), .ovfPulse(ovfPulse)
  );
endmodule

// File: rtl/wdt_rstctl_chk.sv
module wdt_rstctl_chk
  import wdt_rstctl_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 16
) (
  input logic             clk,
  input logic             rstPorN,
  input logic             dblFault,
  input logic             chipRst,
  input logic             wdtIrq,
  input dpStrb_t          strb,
  input logic [CNT_W-1:0] cntVal
);
  logic [15:0] runLen;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)            runLen <= '0;
    else if (!chipRst)       runLen <= '0;
    else if (runLen != '1)   runLen <= runLen + 1'b1;
  end

  // R7
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    wdtIrq |=> !wdtIrq);

  // R6 R8
  pulse_min_len_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    $fell(chipRst) |-> (runLen >= 16'(PULSE_LEN)));

  // R9
  dbl_fault_rst_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    dblFault |=> chipRst);

  // R5
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    (!strb.cntEn && !strb.cntClr) |=> (cntVal == $past(cntVal)));
endmodule

bind wdt_rstctl wdt_rstctl_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) chk_i (
  .clk(clk), .rstPorN(rstPorN), .dblFault(dblFault), .chipRst(chipRst),
  .wdtIrq(wdtIrq), .strb(strb), .cntVal(cntVal)
);

// File: tb/wdt_rstctl_tb_top.sv
module wdt_rstctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 16;
  localparam int NV = 8;
  localparam int vSel [NV] = '{0, 1, 2, 3, 4, 5, 7, 0};
  localparam int vWait[NV] = '{7, 9, 20, 50, 100, 100, 70, 600};
  localparam int vExp [NV] = '{3, 2, 2, 3, 3, 3, 2, 44};

  logic clk = 1'b0;
  logic rstPorN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic dblFault = 1'b0;
  logic chipRst, wdtIrq;
  int nChk = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_rstctl #(.PULSE_LEN(PLEN), .EXP0(1), .EXP1(2), .EXP2(3), .EXP3(4), .EXP4(5)) dut_i (
    .clk(clk), .rstPorN(rstPorN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .dblFault(dblFault), .chipRst(chipRst), .wdtIrq(wdtIrq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = 3'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = 3'(a);
    #1;
    v = int'(rdData);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int v, v2, first, cnt;
    repeat (3) @(negedge clk);
    rstPorN = 1'b1;
    @(negedge clk);
    // R11 reset state
    rd(0, v); chk("R11 cnt", v, 0);
    rd(2, v); chk("R11 ctl", v, 0);
    rd(4, v); chk("R11 rst", v, 0);
    chk("R11 chipRst", int'(chipRst), 0);
    chk("R11 wdtIrq", int'(wdtIrq), 0);

    // R2 R3 vector table: enable + clear + select, then wait
    for (int i = 0; i < NV; i++) begin
      wr(2, 8'hC0 | vSel[i]);
      repeat (vWait[i]) @(negedge clk);
      rd(0, v);
      chk(vSel[i] > 4 ? "R3 alias count" : "R2 count", v, vExp[i]);
    end

    // R4 clear bit reads back 0
    wr(2, 8'hC3);
    rd(2, v); chk("R4 clear reads 0", v, 8'h83);
    repeat (3) @(negedge clk);
    wr(2, 8'hC3);
    rd(0, v); chk("R4 cleared count", v, 0);

    // R5 hold while disabled
    wr(2, 8'h00);
    rd(0, v);
    repeat (40) @(negedge clk);
    rd(0, v2); chk("R5 hold", v2, v);

    // R1 write to counter ignored, unmapped reads
    wr(0, 8'h55);
    rd(0, v2); chk("R1 cnt write ignored", v2, v);
    rd(6, v2); chk("R1 unmapped addr6", v2, 0);
    rd(1, v2); chk("R1 unmapped addr1", v2, 0);

    // R7 overflow with reset disabled
    wr(2, 8'hC0);
    first = -1; cnt = 0; v2 = 0;
    for (int i = 1; i <= 600; i++) begin
      @(negedge clk);
      if (wdtIrq) begin cnt++; if (first < 0) first = i; end
      if (chipRst) v2++;
    end
    chk("R7 irq cycle", first, 512);
    chk("R7 irq width", cnt, 1);
    chk("R7 no chipRst", v2, 0);
    rd(4, v); chk("R7 flag untouched", v, 0);

    // R6 overflow with reset enabled
    wr(4, 8'h08);
    wr(2, 8'hC0);
    first = -1; cnt = 0;
    for (int i = 1; i <= 600; i++) begin
      @(negedge clk);
      if (chipRst) begin cnt++; if (first < 0) first = i; end
      if (i == 512) begin rd(0, v); chk("R6 wrap to 0", v, 0); end
    end
    chk("R6 pulse start", first, 512);
    chk("R6 pulse width", cnt, PLEN);
    wr(2, 8'h00);
    rd(4, v); chk("R6 R10 flag survives pulse", v, 8'h0C);

    // R10 write 1 keeps, write 0 clears
    wr(4, 8'h0E);
    rd(4, v); chk("R10 write1 keeps", v, 8'h0C);
    wr(4, 8'h08);
    rd(4, v); chk("R10 write0 clears", v, 8'h08);

    // R9 double fault
    @(negedge clk); dblFault = 1'b1;
    @(negedge clk); dblFault = 1'b0;
    chk("R9 chipRst start", int'(chipRst), 1);
    rd(4, v); chk("R9 flag set", v, 8'h0A);
    repeat (15) @(negedge clk);
    chk("R9 still high at 16th", int'(chipRst), 1);
    @(negedge clk);
    chk("R9 ended", int'(chipRst), 0);

    // R8 software reset, clear-then-set
    wr(4, 8'h09);
    cnt = int'(chipRst);
    repeat (PLEN + 2) begin @(negedge clk); cnt += int'(chipRst); end
    chk("R8 sw pulse width", cnt, PLEN);
    rd(4, v); chk("R8 R10 df cleared", v, 8'h09);
    wr(4, 8'h09);
    chk("R8 no rearm", int'(chipRst), 0);
    wr(4, 8'h08);
    wr(4, 8'h09);
    chk("R8 rearmed", int'(chipRst), 1);
    repeat (PLEN + 2) @(negedge clk);

    // R11 power-on reset clears flags and control
    wr(2, 8'h84);
    @(negedge clk); dblFault = 1'b1;
    @(negedge clk); dblFault = 1'b0;
    rstPorN = 1'b0;
    @(negedge clk);
    rstPorN = 1'b1;
    @(negedge clk);
    rd(4, v); chk("R11 por rst reg", v, 0);
    rd(2, v); chk("R11 por ctl reg", v, 0);
    chk("R11 por chipRst", int'(chipRst), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule